// File: doc/BRIEF.md
# Collision-Avoidance Beacon and Opportunity Controller

This controller sits on each node of a shared multidrop segment and decides when that node may put a frame on the line. All nodes step through a round of numbered transmit opportunities. Each node keeps a running opportunity number and is granted the line when that number equals its own node number and it has a frame waiting. An opportunity ends either when the carrier of a frame in it goes away or when the line stays quiet for a fixed number of cycles.

The node numbered zero acts as coordinator. Once the last opportunity of a round has ended, it asks its PHY to send a BEACON by driving a transmit-error code on the transmit interface. The BEACON restarts the round on every node. The coordinator does not send the BEACON as soon as the carrier drops. It first waits a guard time, given in clock cycles. With a long enough guard, every observer has dropped its receive-data-valid from the previous frame before the BEACON carrier appears. As a second safeguard, an observer that sees a BEACON while its receive-data-valid is still high stores that event and restarts its round on the first cycle in which receive-data-valid is low.

Top module: `plca_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `opp_id`, `tx_grant`, `tx_er` and `txd` are all 0 after that edge.
- R2: Outside the end-of-round state and outside the post-BEACON wait, the first clock edge that samples `crs` low after an edge that sampled it high increments `opp_id` by one.
- R3: Outside the end-of-round state and outside the post-BEACON wait, `IDLE_TO` consecutive edges with `crs` low (with no carrier fall among them) increment `opp_id` by one.
- R4: When `opp_id` equals `cfg_node_cnt`, the round has ended. `opp_id` then holds its value until a BEACON restarts the round.
- R5: On the coordinator (`cfg_node_id` = 0), the BEACON is driven as `tx_er` = 1 with `txd` = 4'h2 for exactly `BCN_LEN` cycles. At all other times `tx_er` = 0 and `txd` = 0. If the round ends at clock edge k through a carrier fall or an idle timeout, `tx_er` rises at edge k + `cfg_guard` + 1, provided `crs` stays low.
- R6: Any edge in the end-of-round state that samples `crs` high reloads the guard count. If the last high sample is at edge k-1, `tx_er` rises at edge k + `cfg_guard`.
- R7: On the coordinator, `opp_id` is 0 after the edge on which the last BEACON cycle ends.
- R8: On a non-coordinator, a `bcn_seen` pulse sampled while `rx_dv` is low makes `opp_id` 0 at that edge. On the coordinator, `bcn_seen` has no effect.
- R9: On a non-coordinator, a `bcn_seen` sampled while `rx_dv` is high leaves `opp_id` unchanged. `opp_id` becomes 0 on the first later edge that samples `rx_dv` low.
- R10: After a BEACON restart, opportunity counting stays suspended until an edge samples `crs` low. The end of the BEACON carrier is therefore not counted as an opportunity.
- R11: After an edge, `tx_grant` is 1 exactly when `tx_req` was sampled high at that edge, the node is outside the post-BEACON wait, and the updated `opp_id` is below `cfg_node_cnt` and equal to `cfg_node_id`.
- R12: A non-coordinator never drives `tx_er` or a nonzero `txd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_node_id | input | IDW | Local node number; 0 makes this node the coordinator |
| cfg_node_cnt | input | IDW | Number of transmit opportunities in a round |
| cfg_guard | input | GW | Guard time in cycles between carrier drop and BEACON |
| crs | input | 1 | Carrier sense from the PHY |
| rx_dv | input | 1 | Receive data valid from the PHY |
| bcn_seen | input | 1 | One-cycle pulse: PHY detected a BEACON on the line |
| tx_req | input | 1 | Local frame pending |
| tx_grant | output | 1 | Local node may transmit now |
| tx_er | output | 1 | Transmit-error line; high while a BEACON is requested |
| txd | output | 4 | Transmit data code; 4'h2 while a BEACON is requested |
| opp_id | output | IDW | Current transmit opportunity number |

## Verification
The assertions assume that `cfg_node_id`, `cfg_node_cnt` and `cfg_guard` stay constant between resets. The bound on `opp_id` and the coordinator-only BEACON check both depend on this. The bench therefore changes the configuration only while `rst` is high. All inputs are driven on the falling clock edge, so each rising edge samples settled values. `bcn_seen` is pulsed for a single cycle, both with `rx_dv` low and with `rx_dv` high, so that the direct restart and the deferred restart are each exercised.

// File: rtl/plca_pkg.sv
package plca_pkg;
  // Transmit data code that asks the PHY for a BEACON while tx_er is high
  localparam logic [3:0] BCN_CODE = 4'h2;
endpackage

// File: rtl/plca_opp_tracker.sv
module plca_opp_tracker #(
  parameter int IDW     = 4,
  parameter int IDLE_TO = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           is_coord,
  input  logic [IDW-1:0] node_id,
  input  logic [IDW-1:0] node_cnt,
  input  logic           crs,
  input  logic           rx_dv,
  input  logic           bcn_seen,
  input  logic           bcn_done,
  input  logic           tx_req,
  output logic [IDW-1:0] cur_id,
  output logic           eoc,
  output logic           tx_grant
);
  localparam int TOW = $clog2(IDLE_TO + 1);
  localparam logic [TOW-1:0] TO_LAST = TOW'(IDLE_TO - 1);

  logic [IDW-1:0] cur_q, cur_n;
  logic [TOW-1:0] idle_q, idle_n;
  logic           wait_q, wait_n;
  logic           pend_q, pend_n;
  logic           crs_q;
  logic           hit, crs_fall, eoc_w;

  always_comb begin
    eoc_w    = (cur_q >= node_cnt);
    crs_fall = crs_q & ~crs;
    hit      = is_coord ? bcn_done : ((bcn_seen | pend_q) & ~rx_dv);
    cur_n    = cur_q;
    idle_n   = idle_q;
    wait_n   = wait_q;
    // a beacon seen during a late rx_dv is kept until rx_dv drops
    pend_n   = ~is_coord & (bcn_seen | pend_q) & rx_dv;
    if (hit) begin
      cur_n  = '0;
      idle_n = '0;
      wait_n = 1'b1;
      pend_n = 1'b0;
    end else if (wait_q) begin
      idle_n = '0;
      if (!crs) wait_n = 1'b0;
    end else if (eoc_w) begin
      idle_n = '0;
    end else if (crs_fall) begin
      cur_n  = cur_q + 1'b1;
      idle_n = '0;
    end else if (crs) begin
      idle_n = '0;
    end else if (idle_q == TO_LAST) begin
      cur_n  = cur_q + 1'b1;
      idle_n = '0;
    end else begin
      idle_n = idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      idle_q   <= '0;
      wait_q   <= 1'b0;
      pend_q   <= 1'b0;
      crs_q    <= 1'b0;
      tx_grant <= 1'b0;
    end else begin
      cur_q    <= cur_n;
      idle_q   <= idle_n;
      wait_q   <= wait_n;
      pend_q   <= pend_n;
      crs_q    <= crs;
      tx_grant <= tx_req & ~wait_n & (cur_n < node_cnt) & (cur_n == node_id);
    end
  end

  assign cur_id = cur_q;
  assign eoc    = eoc_w;

  // R4
  cur_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cur_q <= node_cnt);
  // R4
  eoc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (eoc_w && !hit) |=> $stable(cur_q));
  // R9
  late_bcn_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !rx_dv) |=> (cur_q == '0));
  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_q && !hit) |=> $stable(cur_q));
endmodule

// File: rtl/plca_bcn_gen.sv
module plca_bcn_gen #(
  parameter int GW      = 12,
  parameter int BCN_LEN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_coord,
  input  logic          eoc,
  input  logic          crs,
  input  logic [GW-1:0] guard_cyc,
  output logic          bcn_done,
  output logic          bcn_on,
  output logic [3:0]    txd
);
  import plca_pkg::*;
  localparam int LW = $clog2(BCN_LEN + 1);

  logic [GW-1:0] grd_q, grd_n;
  logic [LW-1:0] len_q, len_n;

  always_comb begin
    grd_n = grd_q;
    len_n = len_q;
    if (len_q != '0) begin
      len_n = len_q - 1'b1;
    end else if (!(is_coord && eoc) || crs) begin
      grd_n = guard_cyc;
    end else if (grd_q == '0) begin
      len_n = LW'(BCN_LEN);
    end else begin
      grd_n = grd_q - 1'b1;
    end
  end

  assign bcn_done = (len_q == LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      grd_q  <= '0;
      len_q  <= '0;
      bcn_on <= 1'b0;
      txd    <= 4'h0;
    end else begin
      grd_q  <= grd_n;
      len_q  <= len_n;
      bcn_on <= (len_n != '0);
      txd    <= (len_n != '0) ? BCN_CODE : 4'h0;
    end
  end

  // R5
  bcn_code_chk: assert property (@(posedge clk) disable iff (rst)
    bcn_on |-> (txd == BCN_CODE));
  // R12
  coord_only_chk: assert property (@(posedge clk) disable iff (rst)
    bcn_on |-> is_coord);
  // R6
  guard_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bcn_on) |-> $past(grd_q == '0 && !crs));
  // R7
  bcn_end_chk: assert property (@(posedge clk) disable iff (rst)
    bcn_done |=> !bcn_on);
endmodule

// File: rtl/plca_ctrl.sv
module plca_ctrl #(
  parameter int IDW     = 4,
  parameter int GW      = 12,
  parameter int IDLE_TO = 16,
  parameter int BCN_LEN = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IDW-1:0] cfg_node_id,
  input  logic [IDW-1:0] cfg_node_cnt,
  input  logic [GW-1:0]  cfg_guard,
  input  logic           crs,
  input  logic           rx_dv,
  input  logic           bcn_seen,
  input  logic           tx_req,
  output logic           tx_grant,
  output logic           tx_er,
  output logic [3:0]     txd,
  output logic [IDW-1:0] opp_id
);
  logic is_coord, eoc, bcn_done;

  assign is_coord = (cfg_node_id == '0);

  plca_opp_tracker #(.IDW(IDW), .IDLE_TO(IDLE_TO)) u_trk (
    .clk      (clk),
    .rst      (rst),
    .is_coord (is_coord),
    .node_id  (cfg_node_id),
    .node_cnt (cfg_node_cnt),
    .crs      (crs),
    .rx_dv    (rx_dv),
    .bcn_seen (bcn_seen),
    .bcn_done (bcn_done),
    .tx_req   (tx_req),
    .cur_id   (opp_id),
    .eoc      (eoc),
    .tx_grant (tx_grant)
  );

  plca_bcn_gen #(.GW(GW), .BCN_LEN(BCN_LEN)) u_gen (
    .clk       (clk),
    .rst       (rst),
    .is_coord  (is_coord),
    .eoc       (eoc),
    .crs       (crs),
    .guard_cyc (cfg_guard),
    .bcn_done  (bcn_done),
    .bcn_on    (tx_er),
    .txd       (txd)
  );

  // R11
  grant_excl_chk: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> !tx_er);
endmodule

// File: tb/sim_plca_ctrl.sv
module sim_plca_ctrl;
  localparam int IDW = 4, GW = 12, TO = 16, BL = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [IDW-1:0] nid = '0, ncnt = 4'd4;
  logic [GW-1:0] grd = 12'd5;
  logic crs = 0, rxdv = 0, seen = 0, req = 0;
  logic gnt, ter;
  logic [3:0] td;
  logic [IDW-1:0] oid;

  always #4 clk = ~clk;

  plca_ctrl #(.IDW(IDW), .GW(GW), .IDLE_TO(TO), .BCN_LEN(BL)) u0 (
    .clk(clk), .rst(rst), .cfg_node_id(nid), .cfg_node_cnt(ncnt),
    .cfg_guard(grd), .crs(crs), .rx_dv(rxdv), .bcn_seen(seen),
    .tx_req(req), .tx_grant(gnt), .tx_er(ter), .txd(td), .opp_id(oid));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, updated at each rising edge
  int m_cur = 0, m_idle = 0, m_wait = 0, m_pend = 0, m_crsq = 0;
  int m_grd = 0, m_len = 0, m_gnt = 0, m_ter = 0;

  always @(posedge clk) begin : model
    int cur_n, idle_n, wait_n, pend_n, grd_n, len_n;
    bit coord, eoc, hit;
    if (rst) begin
      m_cur = 0; m_idle = 0; m_wait = 0; m_pend = 0; m_crsq = 0;
      m_grd = 0; m_len = 0; m_gnt = 0; m_ter = 0;
    end else begin
      coord = (nid == 0);
      eoc   = (m_cur >= int'(ncnt));
      hit   = coord ? (m_len == 1) : ((seen || m_pend != 0) && !rxdv);
      grd_n = m_grd; len_n = m_len;
      if (m_len > 0) len_n = m_len - 1;
      else if (!(coord && eoc) || crs) grd_n = int'(grd);
      else if (m_grd == 0) len_n = BL;
      else grd_n = m_grd - 1;
      cur_n = m_cur; idle_n = m_idle; wait_n = m_wait;
      pend_n = (!coord && (seen || m_pend != 0) && rxdv) ? 1 : 0;
      if (hit) begin
        cur_n = 0; idle_n = 0; wait_n = 1; pend_n = 0;
      end else if (m_wait != 0) begin
        idle_n = 0;
        if (!crs) wait_n = 0;
      end else if (eoc) idle_n = 0;
      else if (m_crsq != 0 && !crs) begin cur_n = m_cur + 1; idle_n = 0; end
      else if (crs) idle_n = 0;
      else if (m_idle == TO - 1) begin cur_n = m_cur + 1; idle_n = 0; end
      else idle_n = m_idle + 1;
      m_gnt = (req && wait_n == 0 && cur_n < int'(ncnt) && cur_n == int'(nid)) ? 1 : 0;
      m_ter = (len_n > 0) ? 1 : 0;
      m_cur = cur_n; m_idle = idle_n; m_wait = wait_n; m_pend = pend_n;
      m_grd = grd_n; m_len = len_n; m_crsq = crs ? 1 : 0;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!done_flag) begin
      chk(oid === IDW'(m_cur), "R2 R3 R4 R7 R8 R9 R10 opp_id", int'(oid), m_cur);
      chk(gnt === 1'(m_gnt), "R11 tx_grant", int'(gnt), m_gnt);
      chk(ter === 1'(m_ter), "R5 R6 R12 tx_er", int'(ter), m_ter);
      chk(td === (m_ter != 0 ? 4'h2 : 4'h0), "R5 R12 txd", int'(td), m_ter != 0 ? 2 : 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done_flag) begin
      done_flag = 1;
      n_bad++;
      $display("FAIL watchdog all requirements actual=%0d expected=<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pkt(input int n);
    crs = 1; tick(n); crs = 0; tick(1);
  endtask

  task automatic measure(output int k);
    k = 0;
    do begin tick(1); k++; end while (!ter && k < 60);
  endtask

  initial begin
    int k;
    // Phase 1: coordinator
    tick(2);
    chk(oid == 0 && gnt == 0 && ter == 0 && td == 0, "R1 reset outputs",
        int'({gnt, ter, td, oid}), 0);
    req = 1; rst = 0; tick(1);
    chk(gnt == 1, "R11 coordinator grant at opportunity 0", int'(gnt), 1);
    pkt(5);
    chk(oid == 1, "R2 carrier end advances", int'(oid), 1);
    req = 0;
    tick(TO);
    chk(oid == 2, "R3 idle timeout advances", int'(oid), 2);
    tick(TO);
    crs = 1; tick(4); crs = 0;
    seen = 1;
    measure(k);
    seen = 0;
    chk(k == int'(grd) + 2, "R5 guard from round end to BEACON", k, int'(grd) + 2);
    tick(BL + 1);
    chk(oid == 0, "R7 coordinator restarts round after BEACON", int'(oid), 0);
    for (int i = 0; i < 300 && oid != IDW'(4); i++) tick(1);
    crs = 1; tick(2); crs = 0;
    measure(k);
    chk(k == int'(grd) + 1, "R6 carrier during guard reloads it", k, int'(grd) + 1);
    tick(BL + 4);

    // Phase 2: observer node 2
    rst = 1; nid = 4'd2; req = 1; tick(2); rst = 0;
    pkt(3);
    chk(oid == 1, "R2 observer carrier end advances", int'(oid), 1);
    pkt(3);
    chk(gnt == 1, "R11 observer grant at own opportunity", int'(gnt), 1);
    pkt(3);
    tick(TO);
    chk(oid == 4, "R3 observer idle timeout reaches round end", int'(oid), 4);
    tick(TO);
    chk(oid == 4, "R4 round end holds", int'(oid), 4);
    crs = 1; seen = 1; tick(1); seen = 0;
    chk(oid == 0, "R8 BEACON with rx_dv low restarts", int'(oid), 0);
    tick(3); crs = 0; tick(1);
    chk(oid == 0, "R10 BEACON carrier end not counted", int'(oid), 0);
    pkt(3); pkt(3); pkt(3);
    crs = 1; rxdv = 1; tick(3); crs = 0; tick(1);
    chk(oid == 4, "R4 last opportunity ends round", int'(oid), 4);
    seen = 1; tick(1); seen = 0;
    chk(oid == 4, "R9 BEACON during rx_dv is deferred", int'(oid), 4);
    tick(3); rxdv = 0; tick(1);
    chk(oid == 0, "R9 deferred BEACON applied when rx_dv drops", int'(oid), 0);
    tick(10);
    chk(ter == 0 && td == 0, "R12 observer never requests BEACON", int'(ter), 0);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule